// File: doc/BRIEF.md
# Interrupt Entry Privilege Checker

This block decides whether a handler may be entered through an interrupt or trap gate, and what the privilege level and flags word become when it is. For each entry strobe the caller supplies the current privilege level, the kind of event, the gate kind and its privilege, the privilege of the target code segment, and whether that segment is conforming. The block either grants the entry or reports a general-protection fault. A granted entry produces the new privilege level and an edited flags word, and the incoming flags word is kept in an internal saved-flags register. That register takes the place of the stack copy.

A return strobe rebuilds the flags word. The trace, interrupt-enable, nested-task, resume and virtual-mode bits are taken from the saved copy, and all other bits come from the live flags input. Results are registered and appear one cycle after the strobe.

The block is a small state machine whose state register records the outcome of the last cycle:
- `ST_IDLE`: no request.
- `ST_GRANT`: entry accepted.
- `ST_DENY`: entry faulted.
- `ST_RESUME`: return done.

The transitions go:
- An entry strobe moves to `ST_DENY` when the checks fail and to `ST_GRANT` when they pass.
- A return strobe with no entry strobe moves to `ST_RESUME`.
- With no strobe the machine moves to `ST_IDLE`.
- Every state leaves after one cycle, following the same rules.

Top module: `irq_entry_guard`

## Requirements
- R1: After reset `cpl_o` is 0, `flags_o` is 0, and `done_o` and `fault_o` are 0.
- R2: An entry whose target segment privilege `seg_dpl_i` is numerically greater than `cpl_i` faults, whatever the source, gate or conforming bit.
- R3: For a software source (`src_i` = 2'b00), entry faults when `cpl_i` is greater than `gate_dpl_i`.
- R4: For any other `src_i` value (01 hardware interrupt, 10 or 11 processor exception), `gate_dpl_i` has no effect on the outcome or the results.
- R5: A granted entry to a nonconforming segment sets `cpl_o` to `seg_dpl_i`. A granted entry to a conforming segment sets `cpl_o` to `cpl_i`. A nonconforming target of privilege 0 never faults on R2 grounds.
- R6: A granted entry sets `flags_o` to `flags_i` with bits 8 (trace), 14 (nested task), 16 (resume) and 17 (virtual mode) cleared. The saved-flags register captures `flags_i` unchanged.
- R7: On a granted entry, bit 9 (interrupt enable) is cleared when `gate_trap_i` = 0 (interrupt gate) and is copied from `flags_i` when `gate_trap_i` = 1 (trap gate).
- R8: A return sets `flags_o` to `flags_i` with bits 8, 9, 14, 16 and 17 taken from the saved-flags register, and leaves `cpl_o` unchanged.
- R9: A faulting entry leaves `cpl_o`, `flags_o` and the saved-flags register unchanged.
- R10: Results, `done_o` and `fault_o` appear in the cycle after the strobe. `done_o` and `fault_o` are single-cycle pulses, and they are never high together.
- R11: When `enter_valid_i` and `return_valid_i` are high in the same cycle, only the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_valid_i | input | 1 | One-cycle entry request |
| return_valid_i | input | 1 | One-cycle return request |
| src_i | input | 2 | Event source: 00 software, 01 hardware, 10/11 exception |
| gate_trap_i | input | 1 | 1 = trap gate, 0 = interrupt gate |
| gate_dpl_i | input | 2 | Gate privilege |
| seg_dpl_i | input | 2 | Target code segment privilege |
| seg_conf_i | input | 1 | Target segment is conforming |
| cpl_i | input | 2 | Current privilege level |
| flags_i | input | 32 | Live flags word |
| cpl_o | output | 2 | Registered resulting privilege level |
| flags_o | output | 32 | Registered resulting flags word |
| done_o | output | 1 | Entry granted or return finished last cycle |
| fault_o | output | 1 | General-protection fault raised last cycle |

## Verification
The bench uses the default parameters: 2-bit privilege levels and a 32-bit flags word with the edited bits at positions 8, 9, 14, 16 and 17. With these values the privilege and gate space is small enough to sweep completely. The sweep covers every CPL, gate privilege, segment privilege, conforming bit, source and gate kind, so each compare boundary is reached in both directions. Random mixes of entries, returns and simultaneous strobes over random flags words then show that the saved copy survives faults and that untouched flag bits pass through.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [1:0] {
        SRC_SOFT = 2'b00,
        SRC_HW   = 2'b01,
        SRC_EXC  = 2'b10,
        SRC_EXC2 = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_GRANT  = 2'b01,
        ST_DENY   = 2'b10,
        ST_RESUME = 2'b11
    } guard_state_e;
endpackage

// File: rtl/irq_priv_check.sv
module irq_priv_check #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] cpl_i,
    input  logic [PL_W-1:0] gate_dpl_i,
    input  logic [PL_W-1:0] seg_dpl_i,
    input  logic            seg_conf_i,
    input  logic            is_soft_i,
    output logic            deny_o,
    output logic [PL_W-1:0] cpl_next_o
);
    logic seg_too_low;
    logic gate_blocks;

    always_comb begin
        // target less privileged than the caller: numerically larger level
        seg_too_low = (seg_dpl_i > cpl_i);
        // the gate level only guards software-raised events
        gate_blocks = is_soft_i && (cpl_i > gate_dpl_i);
        deny_o      = seg_too_low || gate_blocks;
        cpl_next_o  = seg_conf_i ? cpl_i : seg_dpl_i;
    end
endmodule

// File: rtl/irq_flag_edit.sv
module irq_flag_edit #(
    parameter int FLAGS_W = 32,
    parameter int TF_POS  = 8,
    parameter int IF_POS  = 9,
    parameter int NT_POS  = 14,
    parameter int RF_POS  = 16,
    parameter int VM_POS  = 17
) (
    input  logic [FLAGS_W-1:0] live_i,
    input  logic [FLAGS_W-1:0] saved_i,
    input  logic               trap_gate_i,
    output logic [FLAGS_W-1:0] entry_o,
    output logic [FLAGS_W-1:0] resume_o
);
    localparam logic [FLAGS_W-1:0] ONE        = {{(FLAGS_W-1){1'b0}}, 1'b1};
    localparam logic [FLAGS_W-1:0] ALWAYS_CLR = (ONE << TF_POS) | (ONE << NT_POS)
                                              | (ONE << RF_POS) | (ONE << VM_POS);
    localparam logic [FLAGS_W-1:0] IE_BIT     = ONE << IF_POS;
    localparam logic [FLAGS_W-1:0] RESTORE    = ALWAYS_CLR | IE_BIT;

    always_comb begin
        entry_o  = live_i & ~ALWAYS_CLR;
        if (!trap_gate_i) begin
            entry_o = entry_o & ~IE_BIT;
        end
        resume_o = (live_i & ~RESTORE) | (saved_i & RESTORE);
    end
endmodule

// File: rtl/irq_entry_guard.sv
module irq_entry_guard
    import irq_entry_pkg::*;
#(
    parameter int PL_W    = 2,
    parameter int FLAGS_W = 32,
    parameter int TF_POS  = 8,
    parameter int IF_POS  = 9,
    parameter int NT_POS  = 14,
    parameter int RF_POS  = 16,
    parameter int VM_POS  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_valid_i,
    input  logic               return_valid_i,
    input  logic [1:0]         src_i,
    input  logic               gate_trap_i,
    input  logic [PL_W-1:0]    gate_dpl_i,
    input  logic [PL_W-1:0]    seg_dpl_i,
    input  logic               seg_conf_i,
    input  logic [PL_W-1:0]    cpl_i,
    input  logic [FLAGS_W-1:0] flags_i,
    output logic [PL_W-1:0]    cpl_o,
    output logic [FLAGS_W-1:0] flags_o,
    output logic               done_o,
    output logic               fault_o
);
    guard_state_e       state_q, state_d;
    logic               deny;
    logic [PL_W-1:0]    cpl_next;
    logic [FLAGS_W-1:0] entry_flags, resume_flags;
    logic [FLAGS_W-1:0] saved_q;
    logic [PL_W-1:0]    cpl_q;
    logic [FLAGS_W-1:0] flags_q;
    logic               is_soft;

    assign is_soft = (src_e'(src_i) == SRC_SOFT);

    irq_priv_check #(.PL_W(PL_W)) u_priv (
        .cpl_i      (cpl_i),
        .gate_dpl_i (gate_dpl_i),
        .seg_dpl_i  (seg_dpl_i),
        .seg_conf_i (seg_conf_i),
        .is_soft_i  (is_soft),
        .deny_o     (deny),
        .cpl_next_o (cpl_next)
    );

    irq_flag_edit #(
        .FLAGS_W(FLAGS_W), .TF_POS(TF_POS), .IF_POS(IF_POS),
        .NT_POS(NT_POS), .RF_POS(RF_POS), .VM_POS(VM_POS)
    ) u_flags (
        .live_i      (flags_i),
        .saved_i     (saved_q),
        .trap_gate_i (gate_trap_i),
        .entry_o     (entry_flags),
        .resume_o    (resume_flags)
    );

    // next-state choice: entry wins over return
    always_comb begin
        if (enter_valid_i) begin
            state_d = deny ? ST_DENY : ST_GRANT;
        end else if (return_valid_i) begin
            state_d = ST_RESUME;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // data registers move with the state decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_q   <= '0;
            flags_q <= '0;
            saved_q <= '0;
        end else begin
            unique case (state_d)
                ST_GRANT: begin
                    cpl_q   <= cpl_next;
                    flags_q <= entry_flags;
                    saved_q <= flags_i;
                end
                ST_RESUME: begin
                    flags_q <= resume_flags;
                end
                ST_DENY, ST_IDLE: begin
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        done_o  = 1'b0;
        fault_o = 1'b0;
        unique case (state_q)
            ST_GRANT:  done_o  = 1'b1;
            ST_RESUME: done_o  = 1'b1;
            ST_DENY:   fault_o = 1'b1;
            ST_IDLE:   ;
        endcase
    end

    assign cpl_o   = cpl_q;
    assign flags_o = flags_q;

    AST_LOW_SEG_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid_i && (seg_dpl_i > cpl_i)) |=> fault_o); // R2
    AST_SOFT_GATE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid_i && is_soft && (cpl_i > gate_dpl_i)) |=> fault_o); // R3
    AST_HW_GATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid_i && !is_soft && (seg_dpl_i <= cpl_i)) |=> (done_o && !fault_o)); // R4
    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid_i && !deny) |=> (!flags_o[TF_POS] && !flags_o[NT_POS]
                                      && !flags_o[RF_POS] && !flags_o[VM_POS])); // R6
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_valid_i && deny) |=> ($stable(cpl_o) && $stable(flags_o))); // R9
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o)); // R10
    AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(enter_valid_i)); // R10
    AST_RETURN_KEEPS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        (return_valid_i && !enter_valid_i) |=> $stable(cpl_o)); // R8
endmodule

// File: tb/irq_entry_guard_tb.sv
module irq_entry_guard_tb;
    localparam int FW = 32;
    localparam logic [FW-1:0] CLR4 = (32'h1 << 8) | (32'h1 << 14) | (32'h1 << 16) | (32'h1 << 17);
    localparam logic [FW-1:0] IEB  = 32'h1 << 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enter_valid_i = 1'b0, return_valid_i = 1'b0;
    logic [1:0]    src_i = '0;
    logic          gate_trap_i = 1'b0;
    logic [1:0]    gate_dpl_i = '0, seg_dpl_i = '0, cpl_i = '0;
    logic          seg_conf_i = 1'b0;
    logic [FW-1:0] flags_i = '0;
    logic [1:0]    cpl_o;
    logic [FW-1:0] flags_o;
    logic          done_o, fault_o;

    int checks = 0;
    int fails  = 0;
    logic          m_done = 1'b0;
    logic [1:0]    m_cpl = '0;
    logic [FW-1:0] m_flags = '0, m_saved = '0;

    always #4 clk = ~clk;

    irq_entry_guard u_dut (
        .clk(clk), .rst_n(rst_n), .enter_valid_i(enter_valid_i), .return_valid_i(return_valid_i),
        .src_i(src_i), .gate_trap_i(gate_trap_i), .gate_dpl_i(gate_dpl_i), .seg_dpl_i(seg_dpl_i),
        .seg_conf_i(seg_conf_i), .cpl_i(cpl_i), .flags_i(flags_i), .cpl_o(cpl_o),
        .flags_o(flags_o), .done_o(done_o), .fault_o(fault_o)
    );

    function automatic logic ref_deny(logic [1:0] c, logic [1:0] g, logic [1:0] s, logic [1:0] src);
        return (s > c) || ((src == 2'b00) && (c > g));
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request; enter takes priority (R11)
    task automatic op(logic en, logic rt, logic [1:0] src, logic trap, logic [1:0] g,
                      logic [1:0] s, logic conf, logic [1:0] c, logic [FW-1:0] f, string tag);
        logic exp_fault, exp_done;
        @(negedge clk);
        enter_valid_i = en; return_valid_i = rt; src_i = src; gate_trap_i = trap;
        gate_dpl_i = g; seg_dpl_i = s; seg_conf_i = conf; cpl_i = c; flags_i = f;
        exp_fault = 1'b0; exp_done = 1'b0;
        if (en) begin
            if (ref_deny(c, g, s, src)) exp_fault = 1'b1;
            else begin
                exp_done = 1'b1;
                m_cpl    = conf ? c : s;
                m_flags  = (f & ~CLR4) & (trap ? ~32'h0 : ~IEB);
                m_saved  = f;
            end
        end else if (rt) begin
            exp_done = 1'b1;
            m_flags  = (f & ~(CLR4 | IEB)) | (m_saved & (CLR4 | IEB));
        end
        @(negedge clk);
        enter_valid_i = 1'b0; return_valid_i = 1'b0;
        check({tag, " fault_o R10"}, 64'(fault_o), 64'(exp_fault));
        check({tag, " done_o R10"},  64'(done_o),  64'(exp_done));
        check({tag, " cpl_o"},       64'(cpl_o),   64'(m_cpl));
        check({tag, " flags_o"},     64'(flags_o), 64'(m_flags));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cpl", 64'(cpl_o), 64'h0);
        check("R1 flags", 64'(flags_o), 64'h0);
        check("R1 done", 64'(done_o), 64'h0);
        check("R1 fault", 64'(fault_o), 64'h0);
        rst_n = 1'b1;

        // directed corners
        op(1, 0, 2'b01, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, "R2 seg less privileged");
        op(1, 0, 2'b00, 0, 2, 0, 0, 3, 32'h0003_4300, "R3 soft cpl>gate");
        op(1, 0, 2'b00, 1, 3, 0, 0, 3, 32'h0003_4300, "R3 soft cpl<=gate trap R7");
        op(1, 0, 2'b01, 0, 0, 2, 0, 3, 32'hFFFF_FFFF, "R4 hw ignores gate R5 R7");
        op(1, 0, 2'b10, 1, 0, 3, 1, 3, 32'h0000_0200, "R4 exc conforming R5");
        op(1, 0, 2'b11, 0, 0, 0, 0, 3, 32'h1234_5678, "R5 dpl0 always R6");
        op(0, 1, 2'b00, 0, 0, 0, 0, 0, 32'h0000_0000, "R8 return");
        op(1, 0, 2'b00, 0, 0, 0, 0, 1, 32'hAAAA_AAAA, "R9 fault keeps");
        op(0, 1, 2'b00, 0, 0, 0, 0, 0, 32'h5555_5555, "R9 saved survived fault R8");
        op(1, 1, 2'b01, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, "R11 both strobes");
        op(0, 0, 2'b00, 0, 0, 0, 0, 0, 32'h0, "R10 idle");

        // exhaustive sweep of privilege space
        for (int c = 0; c < 4; c++)
            for (int g = 0; g < 4; g++)
                for (int s = 0; s < 4; s++)
                    for (int k = 0; k < 16; k++)
                        op(1, 0, 2'(k & 3), k[2], 2'(g), 2'(s), k[3], 2'(c),
                           $urandom(), "R2 R3 R4 R5 R6 R7 sweep");

        // random mix
        void'($urandom(32'd5127));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom());
            op(r[0] | r[1], r[2], 2'($urandom()), 1'($urandom()), 2'($urandom()),
               2'($urandom()), 1'($urandom()), 2'($urandom()), $urandom(), "R8 R9 R11 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule